// File: doc/BRIEF.md
# Prefetch FIFO with Random-Read Arbitration

This block lets one processor core share a single-ported word memory between two users: a read-ahead FIFO that streams consecutive words, and a random single-word read port. A start command loads a stream address and flushes the FIFO. The FIFO then fills from that address and keeps refilling as the consumer pops words. The memory sits outside the block. It accepts one access per cycle and returns the data one cycle after the access.

Bit 31 of the start operand selects how the start completes. In blocking mode the requester is held busy until the FIFO is completely full. In no-wait mode the requester is released after two clocks and the fill runs in the background. A random read first spends a fixed number of preparatory cycles. It then competes for the memory, and the fill side always wins. The read result is taken only from the memory access that was granted to that read. It is never taken from whatever word happens to sit on the memory read bus, so a read issued during a background fill waits and then returns correct data.

Top module: `prefetch_rd_arb`

## Requirements
- R1: After reset, start_busy_o, pop_valid_o, rd_valid_o and mem_req_o are all 0.
- R2: A start with start_arg_i[31]=1 (no-wait) raises start_busy_o in the cycle after issue only, and drops it one cycle later.
- R3: A start with start_arg_i[31]=0 (blocking) holds start_busy_o high for DEPTH+1 cycles after issue. start_busy_o falls in the first cycle in which the FIFO holds DEPTH words, and pop_valid_o is then 1.
- R4: Popped words are the memory contents at the start address and then at consecutive addresses, wrapping modulo 2^AW. While the consumer pops every cycle, the FIFO refills fast enough to supply one word per cycle.
- R5: rd_data_o, qualified by rd_valid_o, always equals the memory word at the requested address. This holds at every spacing after a no-wait start.
- R6: A random read that meets no fill demand shows rd_valid_o exactly PREP+2 cycles after its request cycle.
- R7: While the fill side wants the memory, the read port is not granted. After a no-wait start at cycle 0 with no pops, a read issued at cycle s completes at cycle max(DEPTH+2, s+PREP+2).
- R8: A start issued while a fill or a read is in progress flushes the FIFO. pop_valid_o is 0 in the next cycle, and the later pops follow the new address. A pop in the start cycle is discarded. The outstanding read still completes with correct data.
- R9: With an empty FIFO, pop_valid_o is 0 and pop_ready_i has no effect. The first word popped later is still the word at the start address.
- R10: rd_req_i is ignored while rd_ready_o is 0. Each accepted request yields exactly one rd_valid_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command pulse |
| start_arg_i | input | 32 | Bit 31 selects no-wait mode; bits AW-1:0 hold the stream start address |
| start_busy_o | output | 1 | Requester must stay held while high |
| pop_valid_o | output | 1 | FIFO head word is available |
| pop_ready_i | input | 1 | Consumer takes the head word |
| pop_data_o | output | DW | FIFO head word |
| rd_req_i | input | 1 | Random read request |
| rd_addr_i | input | AW | Random read address |
| rd_ready_o | output | 1 | Read port is idle and can accept a request |
| rd_valid_o | output | 1 | Random read result is valid |
| rd_data_o | output | DW | Random read result |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_addr_o | output | AW | Memory access address |
| mem_rdata_i | input | DW | Memory read data, one cycle after the access |

## Verification
If the read port takes data in the wrong cycle, or takes data that belongs to the fill side, the value shows up on rd_data_o in the same cycle that rd_valid_o rises. It then differs from the memory pattern at the requested address. The spacing sweep after a no-wait start exposes this at every offset from 0 to 20 cycles. A wrong occupancy count or a missed flush shows at the pop port within one stream: either a word arrives out of sequence, or the busy window differs from DEPTH+1 cycles. The cycle in which each read completes is compared against its expected position behind the fill. This catches a priority inversion on the first contended read.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
  typedef enum logic [1:0] {RD_IDLE, RD_PREP, RD_ARB, RD_DATA} rd_state_e;
endpackage

// File: rtl/pfa_fifo.sv
module pfa_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 19,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pop_valid_o,
  input  logic          pop_ready_i,
  output logic [DW-1:0] pop_data_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_wr, do_pop;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_valid_o = (cnt_q != '0);
  assign pop_data_o  = slot_q[rp_q];
  assign count_o     = cnt_q;
  assign do_wr       = wr_i & ~flush_i;
  assign do_pop      = pop_valid_o & pop_ready_i & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= inc(wp_q);
      if (do_pop) rp_q <= inc(rp_q);
      cnt_q <= cnt_q + CW'(do_wr) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) slot_q[wp_q] <= wdata_i;
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_wr |-> (cnt_q < CW'(DEPTH) || do_pop));
endmodule

// File: rtl/pfa_rd_port.sv
module pfa_rd_port import pfa_pkg::*; #(
  parameter int AW   = 10,
  parameter int DW   = 32,
  parameter int PREP = 3,
  localparam int PCW = $clog2(PREP + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic          ready_o,
  output logic          want_o,
  output logic [AW-1:0] addr_o,
  input  logic          gnt_i,
  input  logic          rsp_i,
  input  logic [DW-1:0] rdata_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  rd_state_e      st_q;
  logic [PCW-1:0] cnt_q;
  logic [AW-1:0]  addr_q;

  assign ready_o = (st_q == RD_IDLE);
  assign want_o  = (st_q == RD_ARB);
  assign addr_o  = addr_q;
  // only the granted access's own return is taken, never a held bus value
  assign valid_o = (st_q == RD_DATA) & rsp_i;
  assign data_o  = rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RD_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        RD_IDLE: if (req_i) begin
          addr_q <= addr_i;
          cnt_q  <= PCW'(PREP - 1);
          st_q   <= RD_PREP;
        end
        RD_PREP: if (cnt_q == '0) st_q <= RD_ARB;
                 else cnt_q <= cnt_q - 1'b1;
        RD_ARB:  if (gnt_i) st_q <= RD_DATA;
        RD_DATA: if (rsp_i) st_q <= RD_IDLE;
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  assert_rd_granted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(gnt_i));
endmodule

// File: rtl/pfa_arb.sv
module pfa_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fill_want_i,
  input  logic rd_want_i,
  output logic gnt_fill_o,
  output logic gnt_rd_o,
  output logic rsp_fill_o,
  output logic rsp_rd_o
);
  // fill side has fixed priority
  assign gnt_fill_o = fill_want_i;
  assign gnt_rd_o   = rd_want_i & ~fill_want_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_fill_o <= 1'b0;
      rsp_rd_o   <= 1'b0;
    end else begin
      rsp_fill_o <= gnt_fill_o;
      rsp_rd_o   <= gnt_rd_o;
    end
  end
endmodule

// File: rtl/prefetch_rd_arb.sv
module prefetch_rd_arb #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int DEPTH = 19,
  parameter int PREP  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [31:0]   start_arg_i,
  output logic          start_busy_o,
  output logic          pop_valid_o,
  input  logic          pop_ready_i,
  output logic [DW-1:0] pop_data_o,
  input  logic          rd_req_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_ready_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          fill_en_q, nw_pend_q, blk_q;
  logic [AW-1:0] fill_addr_q, rd_addr;
  logic [CW-1:0] count;
  logic [CW:0]   occ;
  logic          fill_want, rd_want, gnt_fill, gnt_rd, rsp_fill, rsp_rd, pop_fire;
  logic          arg_unused;

  assign arg_unused = ^start_arg_i[30:AW];
  assign pop_fire   = pop_valid_o & pop_ready_i;
  assign occ        = {1'b0, count} + (CW+1)'(rsp_fill);
  // slot freed by a pop this cycle may be refetched now
  assign fill_want  = fill_en_q & ~start_i & (occ < (CW+1)'(DEPTH) + (CW+1)'(pop_fire));

  assign mem_req_o    = gnt_fill | gnt_rd;
  assign mem_addr_o   = gnt_fill ? fill_addr_q : rd_addr;
  assign start_busy_o = nw_pend_q | (blk_q & (count != CW'(DEPTH)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_en_q   <= 1'b0;
      nw_pend_q   <= 1'b0;
      blk_q       <= 1'b0;
      fill_addr_q <= '0;
    end else if (start_i) begin
      fill_en_q   <= 1'b1;
      fill_addr_q <= start_arg_i[AW-1:0];
      nw_pend_q   <= start_arg_i[31];
      blk_q       <= ~start_arg_i[31];
    end else begin
      nw_pend_q <= 1'b0;
      if (gnt_fill) fill_addr_q <= fill_addr_q + 1'b1;
      if (blk_q && count == CW'(DEPTH)) blk_q <= 1'b0;
    end
  end

  pfa_arb u_arb (
    .clk_i, .rst_ni,
    .fill_want_i(fill_want), .rd_want_i(rd_want),
    .gnt_fill_o(gnt_fill), .gnt_rd_o(gnt_rd),
    .rsp_fill_o(rsp_fill), .rsp_rd_o(rsp_rd)
  );

  pfa_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i(start_i), .wr_i(rsp_fill), .wdata_i(mem_rdata_i),
    .pop_valid_o, .pop_ready_i, .pop_data_o, .count_o(count)
  );

  pfa_rd_port #(.AW(AW), .DW(DW), .PREP(PREP)) u_rd (
    .clk_i, .rst_ni,
    .req_i(rd_req_i), .addr_i(rd_addr_i), .ready_o(rd_ready_o),
    .want_o(rd_want), .addr_o(rd_addr), .gnt_i(gnt_rd), .rsp_i(rsp_rd),
    .rdata_i(mem_rdata_i), .valid_o(rd_valid_o), .data_o(rd_data_o)
  );

  assert_nowait_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && start_arg_i[31]) |=> start_busy_o);
  assert_blocking_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(start_busy_o) && !$past(nw_pend_q)) |-> (count == CW'(DEPTH)));
  assert_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !pop_valid_o);
  assert_fill_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_want && rd_want) |-> (mem_addr_o == fill_addr_q));
endmodule

// File: tb/sim_prefetch_rd_arb.sv
module sim_prefetch_rd_arb;
  localparam int AW = 10, DW = 32, DEPTH = 19, PREP = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic st = 1'b0, pr = 1'b0, rr = 1'b0;
  logic [31:0] sa = '0;
  logic [AW-1:0] ra = '0;
  logic start_busy_o, pop_valid_o, rd_ready_o, rd_valid_o, mem_req_o;
  logic [DW-1:0] pop_data_o, rd_data_o, mem_rdata = '0;
  logic [AW-1:0] mem_addr_o;

  int errors = 0, checks = 0, cyc = 0;
  bit rd_pend = 0;
  logic [AW-1:0] rd_exp = '0, pop_exp = '0;
  int rd_t0 = 0, rd_lat = 0, rd_done = 0, pops = 0;

  always #2 clk = ~clk;

  prefetch_rd_arb #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .PREP(PREP)) u0 (
    .clk_i(clk), .rst_ni, .start_i(st), .start_arg_i(sa), .start_busy_o,
    .pop_valid_o, .pop_ready_i(pr), .pop_data_o,
    .rd_req_i(rr), .rd_addr_i(ra), .rd_ready_o, .rd_valid_o, .rd_data_o,
    .mem_req_o, .mem_addr_o, .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  always @(posedge clk) if (mem_req_o) mem_rdata <= pat(mem_addr_o);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit s, input logic [31:0] a, input bit r,
                      input logic [AW-1:0] radr, input bit p);
    @(negedge clk);
    cyc++;
    st = s; sa = a; rr = r; ra = radr; pr = p;
    #1;
    if (rd_valid_o) begin
      chk(rd_pend && rd_data_o == pat(rd_exp), "R5 read data", rd_data_o, pat(rd_exp));
      rd_pend = 0; rd_lat = cyc - rd_t0; rd_done++;
    end
    if (pop_valid_o && pr && !st) begin
      chk(pop_data_o == pat(pop_exp), "R4 pop data", pop_data_o, pat(pop_exp));
      pop_exp++; pops++;
    end
    if (st) pop_exp = a[AW-1:0];
    if (r && rd_ready_o) begin
      rd_pend = 1; rd_exp = radr; rd_t0 = cyc;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, '0, 0);
  endtask

  task automatic wait_rd();
    for (int g = 0; g < 300 && rd_pend; g++) step(0, '0, 0, '0, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    finish_run();
  end

  initial begin
    int n, p0, exp_t;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!start_busy_o && !pop_valid_o && !rd_valid_o && !mem_req_o, "R1 reset outputs",
        {start_busy_o, pop_valid_o, rd_valid_o, mem_req_o}, 0);
    rst_ni = 1'b1;
    idle(2);
    chk(!start_busy_o && !pop_valid_o && !mem_req_o, "R1 idle after reset",
        {start_busy_o, pop_valid_o, mem_req_o}, 0);

    // R2 / R9: no-wait start, pop attempt on empty FIFO
    step(1, 32'h8000_0000 | 32'd100, 0, '0, 0);
    step(0, '0, 0, '0, 1);
    chk(start_busy_o == 1'b1, "R2 busy cycle after issue", start_busy_o, 1);
    chk(pop_valid_o == 1'b0, "R9 empty pop_valid", pop_valid_o, 0);
    step(0, '0, 0, '0, 0);
    chk(start_busy_o == 1'b0, "R2 released after two clocks", start_busy_o, 0);
    idle(22);
    p0 = pops;
    for (int i = 0; i < 5; i++) step(0, '0, 0, '0, 1);
    chk(pop_exp == AW'(105), "R9 stream starts at start address", 32'(pop_exp), 105);

    // R3: blocking start busy window
    step(1, 32'd300, 0, '0, 0);
    n = 0;
    for (int g = 0; g < 100; g++) begin
      step(0, '0, 0, '0, 0);
      if (!start_busy_o) break;
      n++;
    end
    chk(n == DEPTH + 1, "R3 blocking busy cycles", n, DEPTH + 1);
    chk(pop_valid_o == 1'b1, "R3 FIFO ready at release", pop_valid_o, 1);
    p0 = pops;
    for (int i = 0; i < DEPTH; i++) step(0, '0, 0, '0, 1);
    chk(pops - p0 == DEPTH, "R3 full FIFO delivers DEPTH words", pops - p0, DEPTH);

    // R4: wrap and back-to-back pops
    step(1, 32'h8000_0000 | 32'((1 << AW) - 5), 0, '0, 0);
    idle(24);
    p0 = pops;
    for (int i = 0; i < 40; i++) step(0, '0, 0, '0, 1);
    chk(pops - p0 == 40, "R4 one word per cycle with wrap", pops - p0, 40);
    idle(6);

    // R6: uncontended read latency
    step(0, '0, 1, AW'(77), 0);
    wait_rd();
    chk(rd_lat == PREP + 2, "R6 uncontended latency", rd_lat, PREP + 2);

    // R10: request while busy is ignored
    n = rd_done;
    step(0, '0, 1, AW'(500), 0);
    step(0, '0, 1, AW'(600), 0);
    chk(rd_ready_o == 1'b0, "R10 not ready while busy", rd_ready_o, 0);
    wait_rd();
    idle(8);
    chk(rd_done - n == 1, "R10 single result", rd_done - n, 1);

    // R7 / R5: spacing sweep after no-wait start
    for (int s = 0; s <= 20; s++) begin
      logic [AW-1:0] ad;
      ad = AW'($urandom);
      step(1, 32'h8000_0000 | 32'($urandom % (1 << AW)), s == 0, ad, 0);
      for (int k = 1; k < s; k++) step(0, '0, 0, '0, 0);
      if (s > 0) step(0, '0, 1, ad, 0);
      wait_rd();
      exp_t = (DEPTH + 2 > s + PREP + 2) ? DEPTH + 2 : s + PREP + 2;
      chk(s + rd_lat == exp_t, "R7 completion cycle after no-wait start", s + rd_lat, exp_t);
      idle(4);
    end

    // R8: restart mid-fill with read outstanding, pop in start cycle dropped
    step(1, 32'h8000_0000 | 32'd40, 0, '0, 0);
    step(0, '0, 1, AW'(900), 0);
    step(0, '0, 0, '0, 0);
    step(1, 32'h8000_0000 | 32'd700, 0, '0, 1);
    step(0, '0, 0, '0, 0);
    chk(pop_valid_o == 1'b0, "R8 flushed after restart", pop_valid_o, 0);
    wait_rd();
    idle(22);
    for (int i = 0; i < 3; i++) step(0, '0, 0, '0, 1);
    chk(pop_exp == AW'(703), "R8 stream follows new address", 32'(pop_exp), 703);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit s, r;
      s = ($urandom % 61) == 0;
      r = !rd_pend && (($urandom % 4) == 0);
      step(s, {1'($urandom), 31'($urandom)}, r, AW'($urandom), 1'($urandom));
    end
    wait_rd();
    chk(!rd_pend, "R5 last random read completed", rd_pend, 0);
    finish_run();
  end
endmodule